// File: doc/BRIEF.md
# Base Address Register Bank with Size Probing

This block holds the six base address register slots of a general-device configuration header and the two decode-enable bits of its command word. Configuration software writes and reads these through a dword-addressed access port with byte enables. Each slot's window size, its kind (memory or port IO), whether it pairs with its neighbour to form a 64-bit memory base, and whether it is prefetchable are fixed by parameters. None of these can be changed at run time.

Software learns each window's size by writing all ones to a slot and reading it back. Address bits below the window size always read back as zero, and the kind and attribute flags always show in the low bits. Once a real base has been written and the matching enable bit is set, the bank compares incoming host memory and IO addresses against every window. It raises one hit line per slot. A slot whose writable bits are all ones is treated as being probed and never produces a hit.

Top module: `barBank`

## Requirements
- R1: Out of reset every implemented slot holds a zero address part, both enable bits are zero, and no hit line is raised.
- R2: Bit 0 of a slot reads 1 for an IO slot and 0 for a memory slot. A memory slot shows 10b in bits 2:1 when it is the low half of a 64-bit pair and 00b otherwise. Bit 3 shows the prefetchable flag. These bits cannot be written.
- R3: Address bits below a slot's window size read back as zero, so writing all ones to a slot of 2^n bytes reads back ~(2^n - 1) with the R2 flags in the low bits.
- R4: A slot whose writable bits (both halves for a 64-bit pair) are all ones raises no hit.
- R5: A 32-bit memory slot hits when the memory enable is set, address bits 63:32 are zero, and address bits 31:n equal the stored base.
- R6: An IO slot hits when the IO enable is set and IO address bits 31:n equal the stored base.
- R7: Clearing the memory enable suppresses every memory hit, and clearing the IO enable suppresses every IO hit.
- R8: A newly written base takes effect on the cycle after the write. The old window stops hitting and the new one starts.
- R9: For a 64-bit pair, the next slot holds address bits 63:32, is fully writable, and has no flag bits. The hit appears on the low slot only and compares all 64 address bits.
- R10: A slot not implemented by parameter reads zero, ignores writes, and never hits.
- R11: Only the bytes whose byte enable is set are written. The bits of an unwritten byte keep their old value.
- R12: Read data and its valid flag appear one cycle after the read request. Dword 1 (the command word) and dwords 4 to 9 (slots 0 to 5) are decoded. Every other dword reads zero.
- R13: The command word has the IO enable in bit 0 and the memory enable in bit 1, both written through byte 0. All its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgRdEn | input | 1 | Configuration read request |
| cfgDwAddr | input | 6 | Dword index within the header |
| cfgByteEn | input | 4 | Byte enables for a write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, one cycle after request |
| cfgRdValid | output | 1 | Read data valid |
| memAddr | input | 64 | Host memory address to decode |
| ioAddr | input | 32 | Host IO address to decode |
| memHit | output | 6 | Per-slot memory window hit |
| ioHit | output | 6 | Per-slot IO window hit |

## Verification
The bound checker watches every cycle that the enable bits gate their hit lines, that IO hits only come from IO slots and memory hits only from memory slots, and that the upper half of a pair, or an unimplemented slot, never hits. It also watches the one-cycle read latency and the zero read-back of undecoded dwords. Other properties need a chosen sequence of writes and addresses, so only the bench scenarios can show them. These are the probe masks, the window edges on both sides, relocation, 64-bit matching, and partial byte writes.

// File: rtl/barPkg.sv
package barPkg;
  localparam int BAR_SLOTS    = 6;
  localparam int DW_CMD       = 1;
  localparam int DW_BAR_FIRST = 4;
  localparam int SLOT_W       = $clog2(BAR_SLOTS);

  typedef struct packed {
    logic [BAR_SLOTS-1:0] barWr;
    logic                 cmdWr;
    logic [3:0]           byteEn;
    logic                 rdStrobe;
    logic                 rdCmd;
    logic                 rdBar;
    logic [SLOT_W-1:0]    rdSlot;
  } cfgStrobe_t;
endpackage

// File: rtl/barCtrl.sv
module barCtrl
  import barPkg::*;
(
  input  logic       cfgWrEn,
  input  logic       cfgRdEn,
  input  logic [5:0] cfgDwAddr,
  input  logic [3:0] cfgByteEn,
  output cfgStrobe_t strobe
);
  logic       isCmd;
  logic       isBar;
  logic [5:0] slotOff;

  always_comb begin
    slotOff = cfgDwAddr - 6'(DW_BAR_FIRST);
    isCmd   = (cfgDwAddr == 6'(DW_CMD));
    isBar   = (cfgDwAddr >= 6'(DW_BAR_FIRST)) &&
              (cfgDwAddr <  6'(DW_BAR_FIRST + BAR_SLOTS));
    strobe          = '0;
    strobe.byteEn   = cfgByteEn;
    strobe.cmdWr    = cfgWrEn && isCmd;
    strobe.rdStrobe = cfgRdEn;
    strobe.rdCmd    = cfgRdEn && isCmd;
    strobe.rdBar    = cfgRdEn && isBar;
    strobe.rdSlot   = slotOff[SLOT_W-1:0];
    for (int i = 0; i < BAR_SLOTS; i++)
      strobe.barWr[i] = cfgWrEn && isBar && (slotOff == 6'(i));
  end
endmodule

// File: rtl/barDatapath.sv
module barDatapath
  import barPkg::*;
#(
  parameter logic [BAR_SLOTS-1:0]   BAR_IMPL      = 6'b101111,
  parameter logic [BAR_SLOTS-1:0]   BAR_IO        = 6'b000010,
  parameter logic [BAR_SLOTS-1:0]   BAR_IS64      = 6'b000100,
  parameter logic [BAR_SLOTS-1:0]   BAR_PREF      = 6'b000100,
  parameter logic [BAR_SLOTS*5-1:0] BAR_SIZE_LOG2 = {5'd12, 5'd0, 5'd0, 5'd20, 5'd8, 5'd11}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic [31:0]          wrData,
  input  logic [63:0]          memAddr,
  input  logic [31:0]          ioAddr,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic [BAR_SLOTS-1:0] memHit,
  output logic [BAR_SLOTS-1:0] ioHit,
  output logic                 cmdIoEn,
  output logic                 cmdMemEn
);
  logic [1:0]                  cmdQ;
  logic [31:0]                 byteMask;
  logic [BAR_SLOTS-1:0][31:0]  barVal;
  logic [BAR_SLOTS-1:0][31:0]  barRd;

  assign byteMask = {{8{strobe.byteEn[3]}}, {8{strobe.byteEn[2]}},
                     {8{strobe.byteEn[1]}}, {8{strobe.byteEn[0]}}};
  assign cmdIoEn  = cmdQ[0];
  assign cmdMemEn = cmdQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) cmdQ <= 2'b00;
    else if (strobe.cmdWr && strobe.byteEn[0]) cmdQ <= wrData[1:0];
  end

  for (genvar i = 0; i < BAR_SLOTS; i++) begin : g_slot
    localparam int  PREV     = (i == 0) ? 0 : i - 1;
    localparam int  NEXT     = (i == BAR_SLOTS - 1) ? i : i + 1;
    localparam bit  IS_UPPER = (i != 0) && BAR_IS64[PREV] && BAR_IMPL[PREV]
                               && !BAR_IO[PREV];
    localparam bit  IMPL     = BAR_IMPL[i] || IS_UPPER;
    localparam bit  IS_IO    = BAR_IO[i] && !IS_UPPER;
    localparam bit  IS_PAIR  = BAR_IS64[i] && BAR_IMPL[i] && !IS_IO && !IS_UPPER
                               && (i < BAR_SLOTS - 1);
    localparam int  SZ       = int'(BAR_SIZE_LOG2[i*5 +: 5]);
    localparam logic [31:0] LOW_FIX = IS_IO ? 32'h3 : 32'hF;
    localparam logic [31:0] WMASK =
      !IMPL    ? 32'h0 :
      IS_UPPER ? 32'hFFFF_FFFF :
                 ((32'hFFFF_FFFF << SZ) & ~LOW_FIX);
    localparam logic [31:0] FIXED =
      (!IMPL || IS_UPPER) ? 32'h0 :
      IS_IO ? 32'h1 : {28'h0, BAR_PREF[i], IS_PAIR, 2'b00};

    logic [31:0] q;
    logic        allOnes;

    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (strobe.barWr[i])
        q <= ((q & ~byteMask) | (wrData & byteMask)) & WMASK;
    end

    assign barVal[i] = q;
    assign barRd[i]  = q | FIXED;

    if (IS_PAIR) begin : g_allPair
      assign allOnes = (q == WMASK) && (barVal[NEXT] == 32'hFFFF_FFFF);
    end else begin : g_allOne
      assign allOnes = (q == WMASK);
    end

    if (!IMPL || IS_UPPER) begin : g_none
      assign memHit[i] = 1'b0;
      assign ioHit[i]  = 1'b0;
    end else if (IS_IO) begin : g_io
      assign memHit[i] = 1'b0;
      assign ioHit[i]  = cmdIoEn && !allOnes && ((ioAddr & WMASK) == q);
    end else if (IS_PAIR) begin : g_mem64
      assign ioHit[i]  = 1'b0;
      assign memHit[i] = cmdMemEn && !allOnes &&
                         ((memAddr[31:0] & WMASK) == q) &&
                         (memAddr[63:32] == barVal[NEXT]);
    end else begin : g_mem32
      assign ioHit[i]  = 1'b0;
      assign memHit[i] = cmdMemEn && !allOnes &&
                         (memAddr[63:32] == 32'h0) &&
                         ((memAddr[31:0] & WMASK) == q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdStrobe;
      if (strobe.rdCmd)      rdData <= {30'h0, cmdQ};
      else if (strobe.rdBar) rdData <= barRd[strobe.rdSlot];
      else                   rdData <= '0;
    end
  end
endmodule

// File: rtl/barBank.sv
module barBank
  import barPkg::*;
#(
  parameter logic [BAR_SLOTS-1:0]   BAR_IMPL      = 6'b101111,
  parameter logic [BAR_SLOTS-1:0]   BAR_IO        = 6'b000010,
  parameter logic [BAR_SLOTS-1:0]   BAR_IS64      = 6'b000100,
  parameter logic [BAR_SLOTS-1:0]   BAR_PREF      = 6'b000100,
  parameter logic [BAR_SLOTS*5-1:0] BAR_SIZE_LOG2 = {5'd12, 5'd0, 5'd0, 5'd20, 5'd8, 5'd11}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [5:0]  cfgDwAddr,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        cfgRdValid,
  input  logic [63:0] memAddr,
  input  logic [31:0] ioAddr,
  output logic [5:0]  memHit,
  output logic [5:0]  ioHit
);
  cfgStrobe_t cfgStrobe;
  logic       cmdIoEn;
  logic       cmdMemEn;

  barCtrl u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgRdEn  (cfgRdEn),
    .cfgDwAddr(cfgDwAddr),
    .cfgByteEn(cfgByteEn),
    .strobe   (cfgStrobe)
  );

  barDatapath #(
    .BAR_IMPL(BAR_IMPL), .BAR_IO(BAR_IO), .BAR_IS64(BAR_IS64),
    .BAR_PREF(BAR_PREF), .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (cfgStrobe),
    .wrData  (cfgWrData),
    .memAddr (memAddr),
    .ioAddr  (ioAddr),
    .rdData  (cfgRdData),
    .rdValid (cfgRdValid),
    .memHit  (memHit),
    .ioHit   (ioHit),
    .cmdIoEn (cmdIoEn),
    .cmdMemEn(cmdMemEn)
  );
endmodule

// File: rtl/barBankChk.sv
module barBankChk #(
  parameter logic [5:0]  BAR_IMPL = 6'b101111,
  parameter logic [5:0]  BAR_IO   = 6'b000010,
  parameter logic [5:0]  BAR_IS64 = 6'b000100
) (
  input logic        clk,
  input logic        rstN,
  input logic        cfgRdEn,
  input logic [5:0]  cfgDwAddr,
  input logic [31:0] cfgRdData,
  input logic        cfgRdValid,
  input logic [5:0]  memHit,
  input logic [5:0]  ioHit,
  input logic        cmdIoEn,
  input logic        cmdMemEn
);
  localparam logic [5:0] UPPER = {BAR_IS64[4:0] & BAR_IMPL[4:0] & ~BAR_IO[4:0], 1'b0};

  logic holeAddr;
  assign holeAddr = !((cfgDwAddr == 6'd1) || ((cfgDwAddr >= 6'd4) && (cfgDwAddr <= 6'd9)));

  assert_mem_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cmdMemEn |-> (memHit == 6'b0));
  assert_io_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cmdIoEn |-> (ioHit == 6'b0));
  assert_kind_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((memHit & BAR_IO) == 6'b0) && ((ioHit & ~BAR_IO) == 6'b0));
  assert_upper_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((memHit | ioHit) & UPPER) == 6'b0);
  assert_unimpl_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((memHit | ioHit) & ~(BAR_IMPL | UPPER)) == 6'b0);
  assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |=> cfgRdValid);
  assert_rd_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> !cfgRdValid);
  assert_hole_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && holeAddr) |=> (cfgRdData == 32'h0));
endmodule

bind barBank barBankChk #(
  .BAR_IMPL(BAR_IMPL), .BAR_IO(BAR_IO), .BAR_IS64(BAR_IS64)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgRdEn(cfgRdEn), .cfgDwAddr(cfgDwAddr),
  .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid), .memHit(memHit),
  .ioHit(ioHit), .cmdIoEn(cmdIoEn), .cmdMemEn(cmdMemEn)
);

// File: tb/barBank_tb.sv
module barBank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [5:0]  cfgDwAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic [63:0] memAddr = '0;
  logic [31:0] ioAddr = '0;
  logic [5:0]  memHit;
  logic [5:0]  ioHit;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  barBank u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgDwAddr(cfgDwAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid), .memAddr(memAddr),
    .ioAddr(ioAddr), .memHit(memHit), .ioHit(ioHit)
  );

  task automatic cfgWrite(input logic [5:0] dw, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgDwAddr = dw; cfgWrData = d; cfgByteEn = be;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  task automatic cfgRead(input logic [5:0] dw, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    cfgRdEn = 1'b1; cfgDwAddr = dw;
    @(negedge clk);
    cfgRdEn = 1'b0;
  endtask

  task automatic probeHits(input logic [63:0] ma, input logic [31:0] ia,
                           input logic [5:0] em, input logic [5:0] ei, input string tag);
    @(negedge clk);
    memAddr = ma; ioAddr = ia;
    #5;
    vectors++;
    if (memHit !== em || ioHit !== ei) begin
      miscompares++;
      $display("FAIL %s: memHit=%b ioHit=%b expected memHit=%b ioHit=%b",
               tag, memHit, ioHit, em, ei);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN && cfgRdValid) begin
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R12: unexpected read data %h, expected no read", cfgRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (cfgRdData !== e) begin
          miscompares++;
          $display("FAIL %s: read %h expected %h", t, cfgRdData, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state, flag bits, unimplemented and hole reads
    cfgRead(6'd4, 32'h0000_0000, "R1 slot0 reset");
    cfgRead(6'd5, 32'h0000_0001, "R2 io slot reset");
    cfgRead(6'd6, 32'h0000_000C, "R2 pair low flags");
    cfgRead(6'd7, 32'h0000_0000, "R9 pair high reset");
    cfgRead(6'd8, 32'h0000_0000, "R10 unimpl reset");
    cfgRead(6'd9, 32'h0000_0000, "R1 slot5 reset");
    cfgRead(6'd1, 32'h0000_0000, "R13 cmd reset");
    cfgRead(6'd0, 32'h0000_0000, "R12 hole dw0");
    cfgRead(6'd15, 32'h0000_0000, "R12 hole dw15");
    probeHits(64'h0, 32'h0, 6'b0, 6'b0, "R1 no hit after reset");

    // size probing
    for (int s = 4; s <= 9; s++) cfgWrite(6'(s), 32'hFFFF_FFFF, 4'hF);
    cfgRead(6'd4, 32'hFFFF_F800, "R3 2KB mask");
    cfgRead(6'd5, 32'hFFFF_FF01, "R3 io 256B mask");
    cfgRead(6'd6, 32'hFFF0_000C, "R3 1MB pair mask");
    cfgRead(6'd7, 32'hFFFF_FFFF, "R9 high all writable");
    cfgRead(6'd8, 32'h0000_0000, "R10 unimpl ignores ones");
    cfgRead(6'd9, 32'hFFFF_F000, "R3 4KB mask");
    cfgWrite(6'd1, 32'h0000_0003, 4'h1);
    probeHits(64'hFFFF_F800, 32'hFFFF_FF00, 6'b0, 6'b0, "R4 probing no hit");
    probeHits(64'hFFFF_FFFF_FFF0_0000, 32'h0, 6'b0, 6'b0, "R4 pair probing no hit");

    // program windows
    cfgWrite(6'd4, 32'hF1BF_F800, 4'hF);
    cfgWrite(6'd5, 32'h0000_1001, 4'hF);
    cfgWrite(6'd6, 32'hE000_0000, 4'hF);
    cfgWrite(6'd7, 32'h0000_0001, 4'hF);
    cfgWrite(6'd9, 32'hF000_0000, 4'hF);
    cfgRead(6'd5, 32'h0000_1001, "R2 io flag after write");
    cfgRead(6'd6, 32'hE000_000C, "R2 flags not writable");
    probeHits(64'hF1BF_F800, 32'h0, 6'b000001, 6'b0, "R5 window start");
    probeHits(64'hF1BF_FFFF, 32'h0, 6'b000001, 6'b0, "R5 window end");
    probeHits(64'hF1BF_F7FF, 32'h0, 6'b0, 6'b0, "R5 below window");
    probeHits(64'hF1C0_0000, 32'h0, 6'b0, 6'b0, "R5 above window");
    probeHits(64'h1_F1BF_F800, 32'h0, 6'b0, 6'b0, "R5 high bits set");
    probeHits(64'hF000_0ABC, 32'h0, 6'b100000, 6'b0, "R5 slot5 hit");
    probeHits(64'h1_E00F_FFFF, 32'h0, 6'b000100, 6'b0, "R9 64-bit hit");
    probeHits(64'h0_E000_0000, 32'h0, 6'b0, 6'b0, "R9 high half mismatch");
    probeHits(64'h0, 32'h0000_10FF, 6'b0, 6'b000010, "R6 io hit");
    probeHits(64'h0, 32'h0000_1100, 6'b0, 6'b0, "R6 io miss");

    // enable gating
    cfgWrite(6'd1, 32'h0000_0001, 4'h1);
    probeHits(64'hF1BF_F800, 32'h0000_1000, 6'b0, 6'b000010, "R7 mem disabled");
    cfgWrite(6'd1, 32'hFFFF_FFFE, 4'hF);
    probeHits(64'hF1BF_F800, 32'h0000_1000, 6'b000001, 6'b0, "R7 io disabled");
    cfgRead(6'd1, 32'h0000_0002, "R13 cmd other bits zero");
    cfgWrite(6'd1, 32'h0000_0003, 4'h0);
    cfgRead(6'd1, 32'h0000_0002, "R11 cmd byte0 disabled");

    // relocation
    cfgWrite(6'd4, 32'hF1BF_F000, 4'hF);
    probeHits(64'hF1BF_F000, 32'h0, 6'b000001, 6'b0, "R8 new window");
    probeHits(64'hF1BF_F800, 32'h0, 6'b0, 6'b0, "R8 old window gone");

    // byte enables
    cfgWrite(6'd9, 32'h1234_5678, 4'b1000);
    cfgRead(6'd9, 32'h1200_0000, "R11 top byte only");
    cfgWrite(6'd9, 32'h0000_AB00, 4'b0010);
    cfgRead(6'd9, 32'h1200_A000, "R11 byte1 masked");

    // unimplemented slot
    cfgWrite(6'd8, 32'hDEAD_B000, 4'hF);
    cfgRead(6'd8, 32'h0000_0000, "R10 write ignored");
    probeHits(64'hDEAD_B000, 32'hDEAD_B000, 6'b0, 6'b0, "R10 no hit");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R12: %0d reads outstanding, expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule